// File: doc/BRIEF.md
# Frame-granular de-interleave buffer controller

This block keeps account of a frame-organised buffer that sits between a two-pass error-correction chain and a serial audio back end in a disc playback path. Each frame holds 24 bytes of user data. The block does not touch the data. It issues the correction kicks for each arriving frame and hands out write and read frame indices for the buffer memory. It also counts how many whole frames are held.

Data is offered to the output side only when the buffer holds more frames than de-interleaving needs. By default that floor is 118 frames, against a physical capacity of 128. A mode register selects between a flush behaviour and a play behaviour. Flush empties the buffer, resets both indices and blocks writes, corrections and output. Play lets frames flow. A write that would exceed capacity is dropped, and a read that would go below the floor is refused. Each of these events leaves a sticky flag that software clears by writing a one.

Top module: `dfc_frame_fifo_ctl`

## Requirements
- R1: While reset is asserted and right after it, the fill level, both indices, both flags, both correction kicks, the write commit, valid, pop and the mode readback are all 0. The mode readback 0 means flush.
- R2: In play, a frame strobe at cycle t raises `corr_kick[0]` in cycle t+1 and `corr_kick[1]` in cycle t+2. `wr_commit` is high in cycle t+2 when that frame is accepted.
- R3: The fill level changes on the clock edge that ends a cycle with an accepted write or a pop. It rises by one for a write alone, falls by one for a pop alone, and stays unchanged when both happen in the same cycle.
- R4: `frm_valid` is high only in play with a fill level above the latency floor `LAT_FRAMES` (default 118). At a fill level of exactly 118 it is low.
- R5: `frm_pop` equals `rd_req` AND `frm_valid`. In play, a `rd_req` while `frm_valid` is low is refused and sets `udf_flag` on the next edge.
- R6: The fill level never exceeds `CAP_FRAMES` (default 128). A frame reaching commit while the fill level is 128 and no pop occurs is dropped, and `ovf_flag` is set on the next edge.
- R7: Both flags are sticky. A one on `ovf_clr` or `udf_clr` clears the matching flag on the next edge. When a set and a clear meet in the same cycle, the flag stays set.
- R8: A cycle with `mode_we`=1 and `mode_sel`=0 puts the block in flush on the next edge and zeroes the fill level, both indices and the correction pipeline. While in flush, strobes cause no kicks, no commits and no valid.
- R9: A cycle with `mode_we`=1 and `mode_sel`=1 enters play on the next edge. Filling then starts from empty, with both indices at 0.
- R10: `wr_ptr` advances by one per accepted write and `rd_ptr` advances by one per pop. Both wrap from `CAP_FRAMES`-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_we | input | 1 | Mode register write strobe |
| mode_sel | input | 1 | Mode value written: 1 play, 0 flush |
| frm_stb | input | 1 | One frame has arrived for correction |
| rd_req | input | 1 | Output side asks for one frame |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| udf_clr | input | 1 | Write-one-to-clear for the underflow flag |
| play_active | output | 1 | Mode register readback, 1 when in play |
| corr_kick | output | CORR_STAGES | Start pulses for the first and second correction passes |
| wr_commit | output | 1 | Frame accepted into the buffer at `wr_ptr` in this cycle |
| wr_ptr | output | PTR_W | Frame index of the next write |
| frm_valid | output | 1 | A frame may be taken |
| frm_pop | output | 1 | Frame at `rd_ptr` is taken in this cycle |
| rd_ptr | output | PTR_W | Frame index of the next read |
| fill_level | output | FILL_W | Frames currently held, an 8-bit status value by default |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
The bench drives a run of back-to-back frames into a full buffer. A design that compares against the wrong limit would let the fill level climb past 128 or raise no overflow. It also runs concurrent reads and writes at capacity, where a wrong full check would drop frames that a pop made room for. It drains the buffer down to the floor to catch an off-by-one that offers a frame at exactly 118. Further cases cover a flag set and clear in the same cycle, a flush arriving while frames are still in the correction pipeline (stale kicks or stale commits would leak), and a return to play that must restart both indices from zero.

// File: rtl/dfc_pkg.sv
`timescale 1ns/1ps
package dfc_pkg;
  localparam int unsigned DFC_LAT_FRAMES   = 118;
  localparam int unsigned DFC_CAP_FRAMES   = 128;
  localparam int unsigned DFC_CORR_STAGES  = 2;
  localparam int unsigned DFC_FRAME_BYTES  = 24;

  typedef enum logic {
    MODE_FLUSH = 1'b0,
    MODE_PLAY  = 1'b1
  } dfc_mode_e;
endpackage

// File: rtl/dfc_corr_pipe.sv
`timescale 1ns/1ps
// Chain of correction-pass start pulses; stage i fires i+1 cycles after a strobe.
module dfc_corr_pipe #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              stb_i,
  output logic [STAGES-1:0] kick_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign stage_d[gi] = run & stb_i;
      end else begin : g_tail
        assign stage_d[gi] = run & stage_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign kick_o = stage_q;
endmodule

// File: rtl/dfc_ptr_ring.sv
`timescale 1ns/1ps
// Frame index that wraps at DEPTH and can be cleared.
module dfc_ptr_ring #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = clr | adv;
    if (clr) begin
      ptr_d = '0;
    end else if (ptr_q == LAST) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dfc_fill_ctl.sv
`timescale 1ns/1ps
// Occupancy counter, release threshold, capacity guard and sticky flags.
module dfc_fill_ctl #(
  parameter int unsigned LAT_FRAMES = 118,
  parameter int unsigned CAP_FRAMES = 128,
  localparam int unsigned FILL_W = $clog2(CAP_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              play,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic              ovf_clr,
  input  logic              udf_clr,
  output logic [FILL_W-1:0] fill_o,
  output logic              valid_o,
  output logic              wr_ok_o,
  output logic              pop_o,
  output logic              ovf_o,
  output logic              udf_o
);
  localparam logic [FILL_W-1:0] FLOOR = FILL_W'(LAT_FRAMES);
  localparam logic [FILL_W-1:0] CEIL  = FILL_W'(CAP_FRAMES);

  logic [FILL_W-1:0] fill_q;
  logic [FILL_W-1:0] fill_d;
  logic              fill_en;
  logic              ovf_q, ovf_d, udf_q, udf_d;
  logic              full, above_floor, valid, pop, wr_ok;
  logic              ovf_set, udf_set;

  always_comb begin
    full        = (fill_q == CEIL);
    above_floor = (fill_q > FLOOR);
    valid       = play & above_floor;
    pop         = rd_req & valid;
    wr_ok       = wr_req & (~full | pop);
    ovf_set     = wr_req & ~wr_ok;
    udf_set     = play & rd_req & ~valid;
  end

  always_comb begin
    fill_en = clr | (wr_ok ^ pop);
    fill_d  = fill_q;
    if (clr) begin
      fill_d = '0;
    end else if (wr_ok && !pop) begin
      fill_d = fill_q + 1'b1;
    end else if (pop && !wr_ok) begin
      fill_d = fill_q - 1'b1;
    end
  end

  always_comb begin
    ovf_d = (ovf_q & ~ovf_clr) | ovf_set;
    udf_d = (udf_q & ~udf_clr) | udf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (fill_en) begin
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign fill_o  = fill_q;
  assign valid_o = valid;
  assign pop_o   = pop;
  assign wr_ok_o = wr_ok;
  assign ovf_o   = ovf_q;
  assign udf_o   = udf_q;
endmodule

// File: rtl/dfc_frame_fifo_ctl.sv
`timescale 1ns/1ps
// Top: mode register, reset release, correction chain, fill control, indices.
module dfc_frame_fifo_ctl
  import dfc_pkg::*;
#(
  parameter int unsigned LAT_FRAMES  = DFC_LAT_FRAMES,
  parameter int unsigned CAP_FRAMES  = DFC_CAP_FRAMES,
  parameter int unsigned CORR_STAGES = DFC_CORR_STAGES,
  localparam int unsigned PTR_W  = (CAP_FRAMES > 1) ? $clog2(CAP_FRAMES) : 1,
  localparam int unsigned FILL_W = $clog2(CAP_FRAMES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_we,
  input  logic                   mode_sel,
  input  logic                   frm_stb,
  input  logic                   rd_req,
  input  logic                   ovf_clr,
  input  logic                   udf_clr,
  output logic                   play_active,
  output logic [CORR_STAGES-1:0] corr_kick,
  output logic                   wr_commit,
  output logic [PTR_W-1:0]       wr_ptr,
  output logic                   frm_valid,
  output logic                   frm_pop,
  output logic [PTR_W-1:0]       rd_ptr,
  output logic [FILL_W-1:0]      fill_level,
  output logic                   ovf_flag,
  output logic                   udf_flag
);
  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  // mode register
  dfc_mode_e mode_q;
  dfc_mode_e mode_d;
  logic      flush_req;
  logic      hold;
  logic      run;

  always_comb begin
    mode_d    = mode_we ? dfc_mode_e'(mode_sel) : mode_q;
    flush_req = mode_we & ~mode_sel;
    hold      = (mode_q == MODE_FLUSH) | flush_req;
    run       = ~hold;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      mode_q <= MODE_FLUSH;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  logic play;
  assign play = (mode_q == MODE_PLAY);

  // correction pass chain
  logic [CORR_STAGES-1:0] kick;

  dfc_corr_pipe #(.STAGES(CORR_STAGES)) u_corr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (run),
    .stb_i  (frm_stb),
    .kick_o (kick)
  );

  // occupancy
  logic wr_ok;
  logic pop;

  dfc_fill_ctl #(
    .LAT_FRAMES (LAT_FRAMES),
    .CAP_FRAMES (CAP_FRAMES)
  ) u_fill (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (hold),
    .play    (play),
    .wr_req  (kick[CORR_STAGES-1]),
    .rd_req  (rd_req),
    .ovf_clr (ovf_clr),
    .udf_clr (udf_clr),
    .fill_o  (fill_level),
    .valid_o (frm_valid),
    .wr_ok_o (wr_ok),
    .pop_o   (pop),
    .ovf_o   (ovf_flag),
    .udf_o   (udf_flag)
  );

  // frame indices
  dfc_ptr_ring #(.DEPTH(CAP_FRAMES)) u_wr_ring (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (hold),
    .adv   (wr_ok),
    .ptr_o (wr_ptr)
  );

  dfc_ptr_ring #(.DEPTH(CAP_FRAMES)) u_rd_ring (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (hold),
    .adv   (pop),
    .ptr_o (rd_ptr)
  );

  assign play_active = play;
  assign corr_kick   = kick;
  assign wr_commit   = wr_ok;
  assign frm_pop     = pop;
endmodule

// File: rtl/dfc_frame_fifo_ctl_chk.sv
`timescale 1ns/1ps
module dfc_frame_fifo_ctl_chk #(
  parameter int unsigned LAT_FRAMES  = 118,
  parameter int unsigned CAP_FRAMES  = 128,
  parameter int unsigned CORR_STAGES = 2,
  localparam int unsigned PTR_W  = (CAP_FRAMES > 1) ? $clog2(CAP_FRAMES) : 1,
  localparam int unsigned FILL_W = $clog2(CAP_FRAMES + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_we,
  input logic                   mode_sel,
  input logic                   rd_req,
  input logic                   ovf_clr,
  input logic                   play_active,
  input logic [CORR_STAGES-1:0] corr_kick,
  input logic                   wr_commit,
  input logic [PTR_W-1:0]       wr_ptr,
  input logic                   frm_valid,
  input logic                   frm_pop,
  input logic [PTR_W-1:0]       rd_ptr,
  input logic [FILL_W-1:0]      fill_level,
  input logic                   ovf_flag,
  input logic                   udf_flag
);
  localparam logic [FILL_W-1:0] FLOOR = FILL_W'(LAT_FRAMES);
  localparam logic [FILL_W-1:0] CEIL  = FILL_W'(CAP_FRAMES);

  logic flush_req;
  assign flush_req = mode_we & ~mode_sel;

  AST_KICK_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_kick[0] && play_active && !flush_req) |=> corr_kick[1]); // R2

  AST_FILL_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (play_active && !flush_req && wr_commit && !frm_pop) |=> (fill_level == $past(fill_level) + 1'b1)); // R3

  AST_POP_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    frm_pop |-> (fill_level > FLOOR)); // R5

  AST_UDF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (play_active && rd_req && !frm_valid) |=> udf_flag); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CEIL); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (fill_level == '0 && wr_ptr == '0 && rd_ptr == '0 && !play_active)); // R8
endmodule

bind dfc_frame_fifo_ctl dfc_frame_fifo_ctl_chk #(
  .LAT_FRAMES  (LAT_FRAMES),
  .CAP_FRAMES  (CAP_FRAMES),
  .CORR_STAGES (CORR_STAGES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .mode_we     (mode_we),
  .mode_sel    (mode_sel),
  .rd_req      (rd_req),
  .ovf_clr     (ovf_clr),
  .play_active (play_active),
  .corr_kick   (corr_kick),
  .wr_commit   (wr_commit),
  .wr_ptr      (wr_ptr),
  .frm_valid   (frm_valid),
  .frm_pop     (frm_pop),
  .rd_ptr      (rd_ptr),
  .fill_level  (fill_level),
  .ovf_flag    (ovf_flag),
  .udf_flag    (udf_flag)
);

// File: tb/dfc_frame_fifo_ctl_bench.sv
`timescale 1ns/1ps
module dfc_frame_fifo_ctl_bench;
  localparam int LAT = 118;
  localparam int CAP = 128;

  logic       clk;
  logic       rst_n;
  logic       mode_we, mode_sel, frm_stb, rd_req, ovf_clr, udf_clr;
  logic       play_active;
  logic [1:0] corr_kick;
  logic       wr_commit;
  logic [6:0] wr_ptr;
  logic       frm_valid;
  logic       frm_pop;
  logic [6:0] rd_ptr;
  logic [7:0] fill_level;
  logic       ovf_flag;
  logic       udf_flag;

  dfc_frame_fifo_ctl u_dfc_frame_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_sel(mode_sel),
    .frm_stb(frm_stb), .rd_req(rd_req), .ovf_clr(ovf_clr), .udf_clr(udf_clr),
    .play_active(play_active), .corr_kick(corr_kick), .wr_commit(wr_commit),
    .wr_ptr(wr_ptr), .frm_valid(frm_valid), .frm_pop(frm_pop), .rd_ptr(rd_ptr),
    .fill_level(fill_level), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_play, m_s1, m_s2, m_fill, m_wp, m_rp, m_ovf, m_udf;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one clock cycle: drive at falling edge, compare, advance model at rising edge
  task automatic cyc(bit stb, bit rd, bit mwe, bit msel, bit oc, bit uc);
    int e_valid, e_pop, e_wr, hold;
    @(negedge clk);
    frm_stb = stb; rd_req = rd; mode_we = mwe; mode_sel = msel;
    ovf_clr = oc; udf_clr = uc;
    #1;
    e_valid = (m_play != 0 && m_fill > LAT) ? 1 : 0;
    e_pop   = (rd && e_valid != 0) ? 1 : 0;
    e_wr    = (m_s2 != 0 && (m_fill < CAP || e_pop != 0)) ? 1 : 0;
    check("R8",  "play_active", int'(play_active), m_play);
    check("R2",  "kick0",       int'(corr_kick[0]), m_s1);
    check("R2",  "kick1",       int'(corr_kick[1]), m_s2);
    check("R2",  "wr_commit",   int'(wr_commit), e_wr);
    check("R4",  "frm_valid",   int'(frm_valid), e_valid);
    check("R5",  "frm_pop",     int'(frm_pop), e_pop);
    check("R3",  "fill_level",  int'(fill_level), m_fill);
    check("R10", "wr_ptr",      int'(wr_ptr), m_wp);
    check("R10", "rd_ptr",      int'(rd_ptr), m_rp);
    check("R6",  "ovf_flag",    int'(ovf_flag), m_ovf);
    check("R5",  "udf_flag",    int'(udf_flag), m_udf);
    @(posedge clk);
    hold  = (m_play == 0 || (mwe && !msel)) ? 1 : 0;
    m_ovf = ((m_ovf != 0 && !oc) || (m_s2 != 0 && e_wr == 0)) ? 1 : 0;
    m_udf = ((m_udf != 0 && !uc) || (m_play != 0 && rd && e_valid == 0)) ? 1 : 0;
    if (hold != 0) begin
      m_s1 = 0; m_s2 = 0; m_fill = 0; m_wp = 0; m_rp = 0;
    end else begin
      m_fill = m_fill + e_wr - e_pop;
      m_wp   = (m_wp + e_wr) % CAP;
      m_rp   = (m_rp + e_pop) % CAP;
      m_s2   = m_s1;
      m_s1   = stb ? 1 : 0;
    end
    if (mwe) m_play = msel ? 1 : 0;
    #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0;
    mode_we = 0; mode_sel = 0; frm_stb = 0; rd_req = 0; ovf_clr = 0; udf_clr = 0;
    m_play = 0; m_s1 = 0; m_s2 = 0; m_fill = 0; m_wp = 0; m_rp = 0; m_ovf = 0; m_udf = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 state under reset
    check("R1", "fill in reset", int'(fill_level), 0);
    check("R1", "flags in reset", int'({ovf_flag, udf_flag}), 0);
    check("R1", "ptrs in reset", int'(wr_ptr) + int'(rd_ptr), 0);
    check("R1", "mode in reset", int'(play_active), 0);
    check("R1", "outputs in reset", int'({corr_kick, wr_commit, frm_valid, frm_pop}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    check("R1", "fill after reset", int'(fill_level), 0);

    // enter play
    cyc(0, 0, 1, 1, 0, 0);
    check("R9", "play entered", int'(play_active), 1);

    // single frame through both passes
    cyc(1, 0, 0, 0, 0, 0);
    idle(3);
    check("R3", "fill after one frame", int'(fill_level), 1);

    // read below the floor
    cyc(0, 1, 0, 0, 0, 0);
    check("R5", "udf after refused read", int'(udf_flag), 1);
    check("R5", "fill untouched by refused read", int'(fill_level), 1);
    cyc(0, 0, 0, 0, 0, 1);
    check("R7", "udf cleared", int'(udf_flag), 0);

    // fill to capacity and beyond
    for (int i = 0; i < 130; i++) cyc(1, 0, 0, 0, 0, 0);
    idle(3);
    check("R6", "fill at capacity", int'(fill_level), 128);
    check("R6", "ovf after drop", int'(ovf_flag), 1);
    check("R10", "wr_ptr wrapped", int'(wr_ptr), 0);

    // concurrent write and read at capacity
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0, 0);
    idle(3);
    check("R3", "fill after concurrent traffic", int'(fill_level), 128);
    check("R10", "rd_ptr after ten pops", int'(rd_ptr), 10);

    cyc(0, 0, 0, 0, 1, 0);
    check("R7", "ovf cleared", int'(ovf_flag), 0);

    // set and clear meeting in one cycle
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    check("R7", "set wins over clear", int'(ovf_flag), 1);
    cyc(0, 0, 0, 0, 1, 0);
    check("R7", "ovf cleared again", int'(ovf_flag), 0);

    // drain down to the floor
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 0, 0);
    check("R4", "fill stops at floor", int'(fill_level), 118);
    check("R4", "no valid at floor", int'(frm_valid), 0);
    check("R5", "udf at floor", int'(udf_flag), 1);
    cyc(0, 0, 0, 0, 0, 1);

    // flush with frames in flight
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0, 0);
    check("R8", "fill zero after flush", int'(fill_level), 0);
    check("R8", "ptrs zero after flush", int'(wr_ptr) + int'(rd_ptr), 0);
    check("R8", "flush mode", int'(play_active), 0);
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, 0);
    check("R8", "no kicks in flush", int'(corr_kick), 0);
    check("R8", "no fill in flush", int'(fill_level), 0);

    // back to play, fill from empty
    cyc(0, 0, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
    idle(3);
    check("R9", "fill restarts from empty", int'(fill_level), 3);
    check("R9", "wr_ptr restarts", int'(wr_ptr), 3);
    check("R9", "rd_ptr restarts", int'(rd_ptr), 0);

    done = 1'b1;
    summary();
  end
endmodule